// File: doc/BRIEF.md
# Multi-Master I2C Byte Engine

This block sequences the master side of an I2C transfer on a bus shared with other masters. Software issues one command at a time: claim the bus with a start, shift a byte out, shift a byte in, issue a repeated start, or release the bus with a stop. The engine drives SCL and SDA through open-drain style drive-low outputs and watches the real wire levels on separate inputs. A companion SCL generator supplies a `tick` strobe, and each bit is split into four ticks.

Each bit the engine transmits with SDA released is compared with the level it samples while SCL is high. A mismatch means another master is driving the bus. The engine then lets go of both lines in the same clock, moves to its passive state without a stop condition, and raises a sticky lost flag. A bus monitor tracks start and stop conditions from any master, so the engine will not try to claim a bus that someone else holds.

Top module: `i2c_mm_engine`

## Requirements
- R1: After reset both drive-low outputs are 0, `busy` and `arb_lost` are 0 and `cmd_ready` is 1.
- R2: Command code 1 (start), accepted only when the engine is idle, `busy` is 0 and `arb_lost` is 0, releases SCL, pulls SDA low while SCL is high, then pulls SCL low and keeps owning the bus.
- R3: Command code 2 (write) shifts `cmd_data` out most significant bit first, changes SDA only while SCL is low, then releases SDA on the ninth bit and stores the sampled level in `rx_nack` (0 means acknowledged).
- R4: Command code 3 (read) releases SDA for eight bits and shifts the sampled levels, first bit into the most significant position, into `rx_byte`. On the ninth bit it drives SDA low when `cmd_nack` is 0 and releases it when `cmd_nack` is 1.
- R5: Command code 4 (stop) pulls SDA low while SCL is low, releases SCL, waits for SCL high, then releases SDA, and the engine becomes idle with both lines released.
- R6: Command code 5 (repeated start), accepted only while the engine owns the bus, produces a start condition with no stop before it. The next write acts as the address byte, whose least significant bit is 1 for read and 0 for write.
- R7: When the engine releases SDA for a transmitted address or data bit, or for the start it attempts, and samples SDA low while SCL is high, it releases both lines in the same clock, issues no stop, sets `arb_lost` and pulses `done`.
- R8: No arbitration check is made on the acknowledge bit of a read, even when that bit is released and another device holds SDA low.
- R9: `arb_lost` stays set until a one-cycle `al_clr` pulse. While it is set, `cmd_ready` is 0 and start commands are refused.
- R10: `busy` is set by any start condition on the wires (SDA falling while SCL high) and cleared by any stop condition (SDA rising while SCL high). While `busy` is 1 an idle engine refuses start.
- R11: The high phase of a bit does not advance until SCL is sampled high, so a device that holds SCL low stretches the bit without corrupting data.
- R12: `done` pulses for one clock when a command finishes or arbitration is lost. A command code that the current state does not accept is ignored and leaves the lines untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Quarter-bit strobe from the SCL generator |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | 1 start, 2 write, 3 read, 4 stop, 5 repeated start |
| cmd_data | input | 8 | Byte to transmit on write |
| cmd_nack | input | 1 | Read: 1 sends not-acknowledge on the ninth bit |
| al_clr | input | 1 | Clears the lost flag |
| cmd_ready | output | 1 | A start or an owned-bus command can be taken |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Bus held by some master |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| rx_nack | output | 1 | Acknowledge level sampled after a write |
| rx_byte | output | 8 | Last byte read |
| scl_i | input | 1 | Sampled SCL wire |
| sda_i | input | 1 | Sampled SDA wire |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |

## Verification
A wrong bit counter or shift register shows up at the next ninth bit: the acknowledge moves, the captured wire byte differs, or `rx_byte` comes out rotated, and all of these are seen at the `done` that closes the byte. A wrong phase state shows up within one bit time. Either SDA moves while SCL is high, which the wire monitor counts as a spurious start or stop, or the engine keeps a line low after losing, which leaves SCL stuck and stops `done` from arriving. A bad busy tracker shows up at the next start command, which is either accepted against a held bus or refused on a free one.

// File: rtl/i2c_mm_engine.sv
module i2c_mm_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_nack,
  input  logic          al_clr,
  output logic          cmd_ready,
  output logic          done,
  output logic          busy,
  output logic          arb_lost,
  output logic          rx_nack,
  output logic [DW-1:0] rx_byte,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_low_o,
  output logic          sda_low_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [2:0] C_START = 3'd1, C_WRITE = 3'd2, C_READ = 3'd3,
                         C_STOP = 3'd4, C_RESTART = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_STRT, S_XFER, S_STOP} st_t;

  st_t           st;
  logic [1:0]    ph;
  logic [CW-1:0] bc;
  logic          rd, nk, sda_d, scl_d;
  logic [DW-1:0] sh;

  wire bus_start = scl_i & scl_d & sda_d & ~sda_i;
  wire bus_stop  = scl_i & scl_d & ~sda_d & sda_i;
  wire last      = (bc == CW'(DW));
  wire drv_low   = rd ? (last & ~nk) : (~last & ~sh[DW-1]);
  wire hi_tick   = tick & (ph == 2'd2) & scl_i;
  wire lose_x    = (st == S_XFER) & hi_tick & ~rd & ~last & sh[DW-1] & ~sda_i;
  wire lose_s    = (st == S_STRT) & hi_tick & ~sda_i;
  wire lose      = lose_x | lose_s;

  assign cmd_ready = ((st == S_IDLE) & ~busy & ~arb_lost) | (st == S_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 2'd0; bc <= '0; rd <= 1'b0; nk <= 1'b0; sh <= '0;
      sda_low_o <= 1'b0; scl_low_o <= 1'b0; arb_lost <= 1'b0; busy <= 1'b0;
      done <= 1'b0; rx_nack <= 1'b0; rx_byte <= '0; sda_d <= 1'b1; scl_d <= 1'b1;
    end else begin
      done  <= 1'b0;
      sda_d <= sda_i;
      scl_d <= scl_i;
      if (bus_start)     busy <= 1'b1;
      else if (bus_stop) busy <= 1'b0;
      if (al_clr) arb_lost <= 1'b0;
      if (lose) begin
        st <= S_IDLE; ph <= 2'd0; sda_low_o <= 1'b0; scl_low_o <= 1'b0;
        arb_lost <= 1'b1; done <= 1'b1;
      end else begin
        case (st)
          S_IDLE:
            if (cmd_valid && cmd_code == C_START && !busy && !arb_lost) begin
              st <= S_STRT; ph <= 2'd0;
            end
          S_HOLD:
            if (cmd_valid) begin
              ph <= 2'd0; bc <= '0;
              case (cmd_code)
                C_WRITE:   begin st <= S_XFER; rd <= 1'b0; sh <= cmd_data; end
                C_READ:    begin st <= S_XFER; rd <= 1'b1; nk <= cmd_nack; end
                C_STOP:    st <= S_STOP;
                C_RESTART: st <= S_STRT;
                default:   ;
              endcase
            end
          S_STRT:
            if (tick) begin
              case (ph)
                2'd0: begin sda_low_o <= 1'b0; ph <= 2'd1; end
                2'd1: begin scl_low_o <= 1'b0; ph <= 2'd2; end
                2'd2: if (scl_i) begin sda_low_o <= 1'b1; ph <= 2'd3; end
                default: begin scl_low_o <= 1'b1; st <= S_HOLD; done <= 1'b1; ph <= 2'd0; end
              endcase
            end
          S_XFER:
            if (tick) begin
              case (ph)
                2'd0: begin sda_low_o <= drv_low; ph <= 2'd1; end
                2'd1: begin scl_low_o <= 1'b0; ph <= 2'd2; end
                2'd2:
                  if (scl_i) begin
                    ph <= 2'd3;
                    if (rd && !last)  sh <= {sh[DW-2:0], sda_i};
                    if (!rd && last)  rx_nack <= sda_i;
                  end
                default: begin
                  scl_low_o <= 1'b1; ph <= 2'd0;
                  if (!rd && !last) sh <= {sh[DW-2:0], 1'b0};
                  if (last) begin
                    st <= S_HOLD; done <= 1'b1; bc <= '0;
                    if (rd) rx_byte <= sh;
                  end else begin
                    bc <= bc + 1'b1;
                  end
                end
              endcase
            end
          S_STOP:
            if (tick) begin
              case (ph)
                2'd0: begin sda_low_o <= 1'b1; ph <= 2'd1; end
                2'd1: begin scl_low_o <= 1'b0; ph <= 2'd2; end
                2'd2: if (scl_i) ph <= 2'd3;
                default: begin sda_low_o <= 1'b0; st <= S_IDLE; done <= 1'b1; ph <= 2'd0; end
              endcase
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r3_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && $past(st) == S_XFER && sda_low_o != $past(sda_low_o)) |-> $past(scl_low_o));

  a_r2_start_edge_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STRT && $rose(sda_low_o)) |-> !scl_low_o);

  a_r5_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!sda_low_o && !scl_low_o));

  a_r7_loss_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (st == S_IDLE && !sda_low_o && !scl_low_o && done));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !al_clr) |=> arb_lost);

  a_r10_no_start_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && (busy || arb_lost)) |=> st == S_IDLE);

  a_r11_high_phase_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_XFER && $past(ph) == 2'd2 && ph == 2'd3) |-> $past(scl_i));
endmodule

// File: tb/i2c_mm_engine_test.sv
module i2c_mm_engine_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic cmd_valid = 1'b0, cmd_nack = 1'b0, al_clr = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic cmd_ready, done, busy, arb_lost, rx_nack, scl_low_o, sda_low_o;
  logic [7:0] rx_byte;
  logic scl_i, sda_i;

  logic peer_sda = 1'b0, man_sda = 1'b0, hold_scl = 1'b0;
  logic peer_en = 1'b1, stretch_en = 1'b0;
  logic [8:0] peer_pat = 9'h1FF;
  logic [8:0] cap = 9'd0;
  logic psda = 1'b1, pscl = 1'b1;
  int cnt = -1, hold_cnt = 0, nstart = 0, nstop = 0, nstretch = 0;
  int vectors = 0, fails = 0, ndone = 0, tdiv = 0;
  bit finished = 0;
  logic [11:0] exp_q[$];

  assign sda_i = !(sda_low_o | peer_sda | man_sda);
  assign scl_i = !(scl_low_o | hold_scl);

  i2c_mm_engine uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .cmd_nack(cmd_nack), .al_clr(al_clr), .cmd_ready(cmd_ready),
    .done(done), .busy(busy), .arb_lost(arb_lost), .rx_nack(rx_nack), .rx_byte(rx_byte),
    .scl_i(scl_i), .sda_i(sda_i), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 0);
  end

  // peer device on the wires: condition counters, bit capture, pattern driver, stretcher
  always @(negedge clk) begin
    int slot;
    if (pscl && scl_i && psda && !sda_i) begin nstart++; cnt = -1; end
    if (pscl && scl_i && !psda && sda_i) nstop++;
    if (!pscl && scl_i) cap = {cap[7:0], sda_i};
    if (pscl && !scl_i) begin
      cnt++;
      if (stretch_en) hold_cnt = 24;
    end
    if (hold_cnt > 0) hold_cnt--;
    hold_scl = (hold_cnt > 0);
    if (!scl_low_o && !scl_i) nstretch++;
    slot = (cnt >= 0) ? cnt % 9 : 0;
    peer_sda = peer_en && (cnt >= 0) && !peer_pat[8 - slot];
    psda = sda_i;
    pscl = scl_i;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [11:0] mk(input bit crx, input logic [7:0] rx, input bit cnk,
                                     input bit nkv, input bit al);
    return {crx, rx, cnk, nkv, al};
  endfunction

  // monitor: pop expected items at each completion pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      logic [11:0] e;
      ndone++;
      if (exp_q.size() == 0) begin
        chk(0, "R12 unexpected done", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk(arb_lost == e[0], "R7/R9 lost flag", int'(arb_lost), int'(e[0]));
        if (e[2]) chk(rx_nack == e[1], "R3 ack sample", int'(rx_nack), int'(e[1]));
        if (e[11]) chk(rx_byte == e[10:3], "R4 read byte", int'(rx_byte), int'(e[10:3]));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] code, input logic [7:0] data, input bit nkv,
                       input logic [8:0] pat, input logic [11:0] expi);
    int n0;
    peer_pat = pat;
    exp_q.push_back(expi);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    n0 = ndone;
    cmd_code = code; cmd_data = data; cmd_nack = nkv; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (ndone == n0) @(negedge clk);
  endtask

  task automatic poke(input logic [2:0] code);
    cmd_code = code; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int s0, p0, d0;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1
    chk(!busy && !arb_lost && cmd_ready, "R1 reset status", {busy, arb_lost, cmd_ready}, 3'b001);
    chk(!sda_low_o && !scl_low_o, "R1 lines released", {sda_low_o, scl_low_o}, 0);

    // R12: write code while idle is ignored
    d0 = ndone;
    poke(3'd2);
    idle(40);
    chk(!sda_low_o && !scl_low_o && ndone == d0, "R12 ignored code", {sda_low_o, scl_low_o}, 0);

    // R2
    issue(3'd1, 8'h00, 0, 9'h1FF, mk(0, 0, 0, 0, 0));
    chk(!sda_i && !scl_i && busy, "R2 start owns bus", {sda_i, scl_i, busy}, 3'b001);
    chk(nstart == 1 && nstop == 0, "R2 start condition", nstart, 1);

    // R3
    issue(3'd2, 8'hA4, 0, 9'h1FE, mk(0, 0, 1, 0, 0));
    chk(cap == {8'hA4, 1'b0}, "R3 wire bits msb first", cap, {8'hA4, 1'b0});
    issue(3'd2, 8'h3C, 0, 9'h1FF, mk(0, 0, 1, 1, 0));
    chk(cap == {8'h3C, 1'b1}, "R3 nack byte on wire", cap, {8'h3C, 1'b1});

    // R6
    s0 = nstart; p0 = nstop;
    issue(3'd5, 8'h00, 0, 9'h1FF, mk(0, 0, 0, 0, 0));
    chk(nstart == s0 + 1 && nstop == p0, "R6 restart without stop", nstop - p0, 0);
    issue(3'd2, 8'hA5, 0, 9'h1FE, mk(0, 0, 1, 0, 0));
    chk(cap[1] == 1'b1 && cap[8:1] == 8'hA5, "R6 address read bit", cap, {8'hA5, 1'b0});

    // R4
    issue(3'd3, 8'h00, 0, {8'h5A, 1'b1}, mk(1, 8'h5A, 0, 0, 0));
    chk(cap[0] == 1'b0, "R4 master ack driven", cap[0], 0);

    // R8
    issue(3'd3, 8'h00, 1, {8'hC3, 1'b0}, mk(1, 8'hC3, 0, 0, 0));
    chk(!arb_lost && scl_low_o, "R8 no loss on read ack", arb_lost, 0);

    // R11
    stretch_en = 1'b1;
    issue(3'd3, 8'h00, 1, {8'h96, 1'b1}, mk(1, 8'h96, 0, 0, 0));
    stretch_en = 1'b0;
    chk(nstretch > 0, "R11 stretch observed", nstretch, 1);
    chk(cap[0] == 1'b1, "R4 master nack released", cap[0], 1);

    // R5
    p0 = nstop;
    issue(3'd4, 8'h00, 0, 9'h1FF, mk(0, 0, 0, 0, 0));
    idle(3);
    chk(sda_i && scl_i && !busy && nstop == p0 + 1, "R5 stop frees bus", {sda_i, scl_i, busy}, 3'b110);

    // R10
    man_sda = 1'b1;
    idle(3);
    chk(busy && !cmd_ready, "R10 foreign start sets busy", {busy, cmd_ready}, 2'b10);
    d0 = ndone;
    poke(3'd1);
    idle(60);
    chk(!sda_low_o && !scl_low_o && ndone == d0, "R10 start refused", {sda_low_o, scl_low_o}, 0);
    man_sda = 1'b0;
    idle(3);
    chk(!busy && cmd_ready, "R10 foreign stop clears busy", busy, 0);

    // R7 loss on data bit
    issue(3'd1, 8'h00, 0, 9'h1FF, mk(0, 0, 0, 0, 0));
    p0 = nstop;
    issue(3'd2, 8'hA5, 0, {8'h95, 1'b1}, mk(0, 0, 0, 0, 1));
    chk(!sda_low_o && !scl_low_o, "R7 lines released", {sda_low_o, scl_low_o}, 0);
    idle(20);
    chk(busy && nstop == p0, "R7 no stop issued", nstop - p0, 0);
    // R9
    chk(arb_lost && !cmd_ready, "R9 flag sticky", {arb_lost, cmd_ready}, 2'b10);
    man_sda = 1'b1; idle(2); peer_en = 1'b0; idle(2); man_sda = 1'b0; idle(3);
    peer_en = 1'b1;
    chk(!busy && arb_lost && !cmd_ready, "R9 start refused while lost", {busy, arb_lost, cmd_ready}, 3'b010);
    d0 = ndone;
    poke(3'd1);
    idle(40);
    chk(!sda_low_o && ndone == d0, "R9 no start while lost", sda_low_o, 0);
    al_clr = 1'b1; @(negedge clk); al_clr = 1'b0; @(negedge clk);
    chk(!arb_lost && cmd_ready, "R9 flag cleared", arb_lost, 0);

    // R7 loss on start
    peer_pat = 9'h1FF;
    exp_q.push_back(mk(0, 0, 0, 0, 1));
    d0 = ndone;
    poke(3'd1);
    man_sda = 1'b1;
    while (ndone == d0) @(negedge clk);
    chk(!sda_low_o && !scl_low_o, "R7 start loss releases", {sda_low_o, scl_low_o}, 0);
    man_sda = 1'b0; idle(3);
    al_clr = 1'b1; @(negedge clk); al_clr = 1'b0; idle(2);

    // recovery transfer
    issue(3'd1, 8'h00, 0, 9'h1FF, mk(0, 0, 0, 0, 0));
    issue(3'd2, 8'h4E, 0, 9'h1FE, mk(0, 0, 1, 0, 0));
    chk(cap == {8'h4E, 1'b0}, "R3 write after recovery", cap, {8'h4E, 1'b0});
    issue(3'd4, 8'h00, 0, 9'h1FF, mk(0, 0, 0, 0, 0));
    idle(3);
    chk(!busy && exp_q.size() == 0, "R12 all completions seen", exp_q.size(), 0);
    summary();
  end
endmodule